// File: doc/BRIEF.md
# Single-Wire Return-to-One Serial Slave

This block is the device end of a one-wire, open-drain serial link whose line idles high. A host starts every bit by pulling the line low. The level that the line holds a fixed time after that falling edge is the bit value, and the line returns high before the next bit. Bytes travel least-significant bit first. The first byte after the link becomes ready is a command. If its top bit is 1, the next byte is write data. If its top bit is 0, the block waits for a register decoder to hand it a reply byte. It then sends that byte back, one bit for each host falling edge, by pulling the line low itself.

On the fabric side the block sees the line through a sampled input and acts on it only through a pull-low enable. A register decoder receives a one-cycle strobe with each completed byte and a flag that marks the byte as a command or as data. For reads, the decoder supplies the reply with a load pulse. All timing counts advance on a clock-enable tick. The timing limits are given in microseconds together with the tick rate, and the block converts them to tick counts. A long low level is a break, which restarts the protocol. A bit gap that is too long in the middle of a byte stops the link until the next break.

Top module: `rto_link_slave`

## Requirements
- R1: After reset the pull-low output is 0, no byte strobe or error pulse is produced, and the block is ready for a command byte.
- R2: A frame whose low phase is shorter than the sample delay is read as 1, and one whose low phase outlasts the sample delay is read as 0. Eight frames form a byte, the first frame being bit 0. The completed byte appears on `rx_byte` with `rx_cmd`=1 when it is a command.
- R3: A command whose bit 7 is 1 makes the following byte write data, reported with `rx_cmd`=0. The block is then ready for a new command.
- R4: A command whose bit 7 is 0 makes the block wait for `tx_load`, then send `tx_byte` LSB first. For a 0 it holds the line low past the sample delay. For a 1 it releases the line after the start time, so the host sees it high at the sample delay. After the eighth bit it is ready for a new command.
- R5: The pull-low output rises only in the cycle after a host falling edge has been detected, and it never asserts while the block receives a command or write data.
- R6: A low level lasting at least the break time discards any partial byte. The next command is accepted only after the line has stayed high for the recovery time, and frames that start before that are ignored.
- R7: If no falling edge follows within the maximum cycle time while a byte is partly received or sent, `proto_err` pulses for one cycle and the partial byte is dropped. All frames are then ignored until a break and its recovery.
- R8: `rx_valid` is a single-cycle pulse for each completed received byte.
- R9: Host frames that arrive after a read command but before `tx_load` are ignored. The block does not drive, and the reply is still sent whole once it is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Clock enable for all timing counts |
| line_in | input | 1 | Sampled level of the serial line |
| drive_low | output | 1 | 1 pulls the open-drain line low |
| rx_valid | output | 1 | One-cycle strobe: byte received |
| rx_byte | output | 8 | Last received byte |
| rx_cmd | output | 1 | 1 if the strobed byte is a command, 0 if write data |
| tx_load | input | 1 | Pulse: load the reply byte for a read |
| tx_byte | input | 8 | Reply byte, taken while tx_load is 1 |
| proto_err | output | 1 | One-cycle pulse on a bit-gap timeout |

## Verification
The bench builds the block with a 100 kHz tick rate, a tick every second clock. The limits then become short counts: sample at 7 ticks, start 3, release 10, break 19, recovery 4, cycle limit 25. With these counts, bits, breaks and timeouts take only tens of clocks, so a run can cover writes, reads, break recovery and the error lockout. The host's frame timings sit clearly on either side of each limit, which makes every decision point in the block observable at the line and at the byte strobe.

// File: rtl/rto_pkg.sv
package rto_pkg;

  typedef enum logic [2:0] {
    ST_CMD    = 3'd0,
    ST_WDATA  = 3'd1,
    ST_TXWAIT = 3'd2,
    ST_TX     = 3'd3,
    ST_HALT   = 3'd4,
    ST_RECOV  = 3'd5
  } rto_state_e;

  // Converts a duration in microseconds to whole ticks, never below one.
  function automatic int us_to_ticks(input int tick_hz, input int dur_us);
    longint prod;
    longint q;
    prod = longint'(tick_hz) * longint'(dur_us);
    q    = prod / 64'sd1000000;
    if (q < 1) q = 1;
    return int'(q);
  endfunction

endpackage

// File: rtl/rto_sync_edge.sv
module rto_sync_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  input  logic mask,
  output logic line_s,
  output logic fall
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;
  logic       prev_q;
  logic       prev_d;

  always_comb begin
    sync_d = {sync_q[0], line_in};
    prev_d = sync_q[1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign line_s = sync_q[1];
  assign fall   = prev_q & ~sync_q[1] & ~mask;

endmodule

// File: rtl/rto_break_det.sv
module rto_break_det #(
  parameter int BRK_T = 190,
  parameter int REC_T = 40
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic line_s,
  input  logic mask,
  output logic brk,
  output logic rec_done
);

  localparam int CMAX = (BRK_T > REC_T) ? BRK_T : REC_T;
  localparam int CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] BRK_LAST = CW'(BRK_T - 1);
  localparam logic [CW-1:0] REC_LAST = CW'(REC_T - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          in_rec_q, in_rec_d;
  logic          brk_q, brk_d;
  logic          rec_q, rec_d;

  always_comb begin
    cnt_d    = cnt_q;
    in_rec_d = in_rec_q;
    brk_d    = 1'b0;
    rec_d    = 1'b0;
    if (mask) begin
      cnt_d = '0;
    end else if (!in_rec_q) begin
      if (line_s) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == BRK_LAST) begin
          brk_d    = 1'b1;
          in_rec_d = 1'b1;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end else begin
      if (!line_s) begin
        cnt_d = '0;
      end else if (tick) begin
        if (cnt_q == REC_LAST) begin
          rec_d    = 1'b1;
          in_rec_d = 1'b0;
          cnt_d    = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      in_rec_q <= 1'b0;
      brk_q    <= 1'b0;
      rec_q    <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      in_rec_q <= in_rec_d;
      brk_q    <= brk_d;
      rec_q    <= rec_d;
    end
  end

  assign brk      = brk_q;
  assign rec_done = rec_q;

endmodule

// File: rtl/rto_frame_ctrl.sv
module rto_frame_ctrl
  import rto_pkg::*;
#(
  parameter int SAMPLE_T = 75,
  parameter int START_T  = 30,
  parameter int DRVEND_T = 100,
  parameter int CYC_T    = 250
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_s,
  input  logic       fall,
  input  logic       brk,
  input  logic       rec_done,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       drive_low,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_cmd,
  output logic       proto_err
);

  localparam int TMAX = (CYC_T > DRVEND_T) ? CYC_T : DRVEND_T;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [TW-1:0] T_SAMPLE = TW'(SAMPLE_T);
  localparam logic [TW-1:0] T_START  = TW'(START_T);
  localparam logic [TW-1:0] T_DRVEND = TW'(DRVEND_T);
  localparam logic [TW-1:0] T_CYC    = TW'(CYC_T);

  rto_state_e    st_q, st_d;
  logic [TW-1:0] t_q, t_d;
  logic          in_bit_q, in_bit_d;
  logic [2:0]    bitcnt_q, bitcnt_d;
  logic [7:0]    shreg_q, shreg_d;
  logic [7:0]    txsh_q, txsh_d;
  logic          txbit_q, txbit_d;
  logic          drv_q, drv_d;
  logic          rxv_q, rxv_d;
  logic [7:0]    rxb_q, rxb_d;
  logic          rxc_q, rxc_d;
  logic          err_q, err_d;
  logic          bit_state;

  assign bit_state = (st_q == ST_CMD) || (st_q == ST_WDATA) || (st_q == ST_TX);

  always_comb begin
    st_d     = st_q;
    t_d      = t_q;
    in_bit_d = in_bit_q;
    bitcnt_d = bitcnt_q;
    shreg_d  = shreg_q;
    txsh_d   = txsh_q;
    txbit_d  = txbit_q;
    drv_d    = drv_q;
    rxv_d    = 1'b0;
    rxb_d    = rxb_q;
    rxc_d    = rxc_q;
    err_d    = 1'b0;

    // time since the last host falling edge, saturating at the cycle limit
    if (fall) begin
      t_d = '0;
    end else if (tick && (t_q != T_CYC)) begin
      t_d = t_q + 1'b1;
    end

    // release the line once the hold for the current reply bit is over
    if (drv_q && (t_q >= (txbit_q ? T_START : T_DRVEND))) begin
      drv_d = 1'b0;
    end

    if (bit_state) begin
      if (fall) begin
        in_bit_d = 1'b1;
        if (st_q == ST_TX) begin
          drv_d   = 1'b1;
          txbit_d = txsh_q[0];
        end
      end else if (in_bit_q && tick && (t_q == T_SAMPLE)) begin
        in_bit_d = 1'b0;
        shreg_d  = {line_s, shreg_q[7:1]};
        txsh_d   = {1'b0, txsh_q[7:1]};
        bitcnt_d = 3'(bitcnt_q + 3'd1);
        if (bitcnt_q == 3'd7) begin
          if (st_q == ST_TX) begin
            st_d = ST_CMD;
          end else begin
            rxv_d = 1'b1;
            rxb_d = {line_s, shreg_q[7:1]};
            rxc_d = (st_q == ST_CMD);
            if (st_q == ST_CMD) begin
              st_d = line_s ? ST_WDATA : ST_TXWAIT;
            end else begin
              st_d = ST_CMD;
            end
          end
        end
      end else if ((bitcnt_q != 3'd0) && !in_bit_q && (t_q == T_CYC)) begin
        err_d    = 1'b1;
        st_d     = ST_HALT;
        bitcnt_d = 3'd0;
      end
    end else if (st_q == ST_TXWAIT) begin
      in_bit_d = 1'b0;
      if (tx_load) begin
        txsh_d   = tx_byte;
        bitcnt_d = 3'd0;
        st_d     = ST_TX;
      end
    end else begin
      in_bit_d = 1'b0;
      if ((st_q == ST_RECOV) && rec_done) begin
        st_d     = ST_CMD;
        bitcnt_d = 3'd0;
      end
    end

    if (brk) begin
      st_d     = ST_RECOV;
      bitcnt_d = 3'd0;
      in_bit_d = 1'b0;
      drv_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_CMD;
      t_q      <= '0;
      in_bit_q <= 1'b0;
      bitcnt_q <= 3'd0;
      shreg_q  <= 8'h00;
      txsh_q   <= 8'h00;
      txbit_q  <= 1'b0;
      drv_q    <= 1'b0;
      rxv_q    <= 1'b0;
      rxb_q    <= 8'h00;
      rxc_q    <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      st_q     <= st_d;
      t_q      <= t_d;
      in_bit_q <= in_bit_d;
      bitcnt_q <= bitcnt_d;
      shreg_q  <= shreg_d;
      txsh_q   <= txsh_d;
      txbit_q  <= txbit_d;
      drv_q    <= drv_d;
      rxv_q    <= rxv_d;
      rxb_q    <= rxb_d;
      rxc_q    <= rxc_d;
      err_q    <= err_d;
    end
  end

  assign drive_low = drv_q;
  assign rx_valid  = rxv_q;
  assign rx_byte   = rxb_q;
  assign rx_cmd    = rxc_q;
  assign proto_err = err_q;

endmodule

// File: rtl/rto_link_slave.sv
module rto_link_slave
  import rto_pkg::*;
#(
  parameter int TICK_HZ    = 1000000,
  parameter int SAMPLE_US  = 75,
  parameter int START_US   = 30,
  parameter int DRVEND_US  = 100,
  parameter int CYC_MAX_US = 250,
  parameter int BREAK_US   = 190,
  parameter int BRKREC_US  = 40
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       line_in,
  output logic       drive_low,
  output logic       rx_valid,
  output logic [7:0] rx_byte,
  output logic       rx_cmd,
  input  logic       tx_load,
  input  logic [7:0] tx_byte,
  output logic       proto_err
);

  localparam int SAMPLE_T = us_to_ticks(TICK_HZ, SAMPLE_US);
  localparam int START_T  = us_to_ticks(TICK_HZ, START_US);
  localparam int DRVEND_T = us_to_ticks(TICK_HZ, DRVEND_US);
  localparam int CYC_T    = us_to_ticks(TICK_HZ, CYC_MAX_US);
  localparam int BRK_T    = us_to_ticks(TICK_HZ, BREAK_US);
  localparam int REC_T    = us_to_ticks(TICK_HZ, BRKREC_US);

  logic [1:0] rst_sync_q;
  logic       rst_i;
  logic       line_s;
  logic       fall_w;
  logic       brk_w;
  logic       rec_w;
  logic       drv_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_i = rst_sync_q[1];

  rto_sync_edge i_sync (
    .clk     (clk),
    .rst_n   (rst_i),
    .line_in (line_in),
    .mask    (drv_w),
    .line_s  (line_s),
    .fall    (fall_w)
  );

  rto_break_det #(
    .BRK_T (BRK_T),
    .REC_T (REC_T)
  ) i_brk (
    .clk      (clk),
    .rst_n    (rst_i),
    .tick     (tick),
    .line_s   (line_s),
    .mask     (drv_w),
    .brk      (brk_w),
    .rec_done (rec_w)
  );

  rto_frame_ctrl #(
    .SAMPLE_T (SAMPLE_T),
    .START_T  (START_T),
    .DRVEND_T (DRVEND_T),
    .CYC_T    (CYC_T)
  ) i_frame (
    .clk       (clk),
    .rst_n     (rst_i),
    .tick      (tick),
    .line_s    (line_s),
    .fall      (fall_w),
    .brk       (brk_w),
    .rec_done  (rec_w),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .drive_low (drv_w),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_cmd    (rx_cmd),
    .proto_err (proto_err)
  );

  assign drive_low = drv_w;

endmodule

// File: rtl/rto_link_slave_chk.sv
module rto_link_slave_chk (
  input logic clk,
  input logic rst_n,
  input logic rx_valid,
  input logic proto_err,
  input logic drive_low,
  input logic fall,
  input logic brk
);

  // R8: byte strobe lasts one cycle
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5: pulling low always follows a detected host falling edge
  p_drive_after_edge_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drive_low) |-> $past(fall));

  // R5: no driving while a received byte is being delivered
  p_no_drive_on_rx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !drive_low);

  // R6: a break silences the line driver and the byte strobe
  p_break_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> (!drive_low && !rx_valid));

  // R7: error pulse is single and never coincides with a byte
  p_err_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> !proto_err);

  p_err_no_byte_r7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> (!rx_valid && !drive_low));

endmodule

bind rto_link_slave rto_link_slave_chk i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_valid  (rx_valid),
  .proto_err (proto_err),
  .drive_low (drive_low),
  .fall      (fall_w),
  .brk       (brk_w)
);

// File: tb/test_rto_link_slave.sv
`timescale 1ns/1ps
module test_rto_link_slave;

  logic       clk;
  logic       rst_n;
  logic       tick;
  logic       host_low;
  logic       line;
  logic       drive_low;
  logic       rx_valid;
  logic [7:0] rx_byte;
  logic       rx_cmd;
  logic       tx_load;
  logic [7:0] tx_byte;
  logic       proto_err;

  int checks;
  int errors;
  int rx_cnt;
  int err_cnt;
  int drv_cnt;
  logic [7:0] last_byte;
  logic       last_cmd;
  logic       done;

  // {command, write data, reply}
  localparam logic [23:0] VEC [6] = '{
    {8'h85, 8'h3C, 8'h00},
    {8'h01, 8'h00, 8'hA5},
    {8'h80, 8'hFF, 8'h00},
    {8'h7F, 8'h00, 8'h00},
    {8'hFE, 8'h01, 8'h00},
    {8'h00, 8'h00, 8'hFF}
  };

  assign line = ~(host_low | drive_low);

  rto_link_slave #(
    .TICK_HZ (100000)
  ) i_rto_link_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .line_in   (line),
    .drive_low (drive_low),
    .rx_valid  (rx_valid),
    .rx_byte   (rx_byte),
    .rx_cmd    (rx_cmd),
    .tx_load   (tx_load),
    .tx_byte   (tx_byte),
    .proto_err (proto_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (!rst_n) tick <= 1'b0;
    else        tick <= ~tick;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin
        rx_cnt    <= rx_cnt + 1;
        last_byte <= rx_byte;
        last_cmd  <= rx_cmd;
      end
      if (proto_err) err_cnt <= err_cnt + 1;
      if (drive_low) drv_cnt <= drv_cnt + 1;
    end
  end

  task automatic clocks(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b);
    host_low = 1'b1;
    clocks(b ? 6 : 30);
    host_low = 1'b0;
    clocks(b ? 34 : 10);
  endtask

  task automatic send_byte(input logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(v[i]);
    clocks(4);
  endtask

  task automatic read_bit(output logic r);
    host_low = 1'b1;
    clocks(6);
    host_low = 1'b0;
    clocks(10);
    r = line;
    clocks(24);
  endtask

  task automatic read_byte(output logic [7:0] v);
    logic b;
    for (int i = 0; i < 8; i++) begin
      read_bit(b);
      v[i] = b;
    end
  endtask

  task automatic send_break();
    host_low = 1'b1;
    clocks(50);
    host_low = 1'b0;
    clocks(20);
  endtask

  task automatic load_reply(input logic [7:0] v);
    tx_byte = v;
    tx_load = 1'b1;
    clocks(1);
    tx_load = 1'b0;
    clocks(2);
  endtask

  initial begin
    done = 1'b0;
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       b;
    int         base_rx;
    int         base_drv;
    checks = 0; errors = 0; rx_cnt = 0; err_cnt = 0; drv_cnt = 0;
    last_byte = 8'h00; last_cmd = 1'b0;
    host_low = 1'b0; tx_load = 1'b0; tx_byte = 8'h00;
    rst_n = 1'b0;
    clocks(5);
    rst_n = 1'b1;
    clocks(10);

    // R1: idle after reset
    chk("R1 drive", drive_low, 0);
    chk("R1 strobes", rx_cnt + err_cnt, 0);

    // table walk: R2 bytes LSB first, R3 writes, R4 reads
    foreach (VEC[k]) begin
      base_rx  = rx_cnt;
      base_drv = drv_cnt;
      send_byte(VEC[k][23:16]);
      chk("R2 cmd byte", last_byte, VEC[k][23:16]);
      chk("R2 cmd flag", last_cmd, 1);
      if (VEC[k][23]) begin
        send_byte(VEC[k][15:8]);
        chk("R3 data byte", last_byte, VEC[k][15:8]);
        chk("R3 data flag", last_cmd, 0);
        chk("R5 no drive on write", drv_cnt, base_drv);
      end else begin
        load_reply(VEC[k][7:0]);
        read_byte(rd);
        clocks(4);
        chk("R4 reply", rd, VEC[k][7:0]);
      end
      chk("R8 one strobe per byte", rx_cnt - base_rx, VEC[k][23] ? 2 : 1);
    end

    // R4: after a read the block takes a new command
    send_byte(8'h92);
    send_byte(8'h44);
    chk("R4 back to command", {last_cmd, last_byte}, {1'b0, 8'h44});

    // R9: frames before the reply is loaded are ignored
    send_byte(8'h02);
    base_drv = drv_cnt;
    read_bit(b);
    chk("R9 no drive early", drv_cnt, base_drv);
    chk("R9 line high", b, 1);
    load_reply(8'h6E);
    read_byte(rd);
    clocks(4);
    chk("R9 reply intact", rd, 8'h6E);

    // R6: break discards a partial byte
    for (int i = 0; i < 4; i++) send_bit(1'b0);
    send_break();
    base_rx = rx_cnt;
    send_byte(8'hC3);
    send_byte(8'h5A);
    chk("R6 after break count", rx_cnt - base_rx, 2);
    chk("R6 after break byte", last_byte, 8'h5A);

    // R6: a frame inside the recovery time is ignored
    host_low = 1'b1;
    clocks(50);
    host_low = 1'b0;
    clocks(4);
    send_bit(1'b1);
    base_rx = rx_cnt;
    send_byte(8'h8A);
    chk("R6 recovery cmd", {last_cmd, last_byte}, {1'b1, 8'h8A});
    send_byte(8'h0F);
    chk("R6 recovery count", rx_cnt - base_rx, 2);

    // R7: timeout mid-byte, then lockout until break
    base_rx = rx_cnt;
    for (int i = 0; i < 3; i++) send_bit(1'b1);
    clocks(60);
    chk("R7 error pulse", err_cnt, 1);
    send_byte(8'h81);
    chk("R7 locked out", rx_cnt, base_rx);
    send_break();
    send_byte(8'h81);
    send_byte(8'h77);
    chk("R7 resumes after break", {last_cmd, last_byte}, {1'b0, 8'h77});
    chk("R7 single error", err_cnt, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule